// File: doc/BRIEF.md
# Ticket Lock Arbiter

This block guards one shared resource for a set of requesting agents and hands it out strictly in the order requests arrive. It keeps two counters. The issue counter holds the next ticket number to give out. The serving counter holds the ticket that currently owns the resource. An agent that raises its acquire line gets a ticket: the issue counter's value before an atomic increment. The agent owns the resource while the serving counter matches that ticket. A release from the owner moves the serving counter on by one, and the next ticket in line takes over.

Each agent may hold at most one outstanding ticket. When several agents ask in the same cycle, tickets go out in ascending agent index. Handoff therefore follows ticket order, and no waiting agent can be skipped. A release from an agent that does not own the resource changes nothing and raises a one-cycle error flag. Both counters are sized to log2(N)+1 bits and wrap silently. Ownership is tested by modular equality, so wrap-around has no effect on order.

Top module: `ticket_lock_arbiter`

## Requirements
- R1: After reset both counters are zero, no agent has a valid ticket, no grant is asserted, and `relError` is low.
- R2: An acquire from an agent without a valid ticket sets its `ticketValid` bit on the following cycle. Its ticket field then holds the issue counter's value before the increment, and the issue counter advances.
- R3: When several agents acquire in the same cycle, they receive consecutive ticket values in ascending agent index, lowest index first.
- R4: `grant[i]` is high exactly when `ticketValid[i]` is high and agent i's ticket equals the serving counter modulo 2^(log2(N)+1).
- R5: A release from the agent whose grant is high advances the serving counter by one. On the next cycle that agent's `ticketValid` is low, and the holder of the following ticket, if any, sees its grant rise.
- R6: A release from an agent whose grant is low leaves all counters and tickets unchanged. It drives `relError` high for exactly the following cycle.
- R7: An acquire from an agent that already holds a valid ticket is ignored. Its ticket is unchanged and the issue counter does not advance.
- R8: At most one grant is high in any cycle, and grants are handed over in ticket (arrival) order.
- R9: Both counters wrap modulo 2^(log2(N)+1), and the number of outstanding tickets never exceeds N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acqReq | input | NUM_AGENTS | Per-agent acquire request, sampled each clock |
| relReq | input | NUM_AGENTS | Per-agent release request, sampled each clock |
| ticketValid | output | NUM_AGENTS | Agent holds an outstanding ticket |
| ticketOut | output | NUM_AGENTS*CNT_W | Ticket of agent i at bits [i*CNT_W +: CNT_W] |
| grant | output | NUM_AGENTS | Agent currently owns the lock |
| relError | output | 1 | One-cycle flag for a release from a non-owner |

## Verification
All state sits behind one register stage. A ticket requested at a rising edge shows on `ticketValid`/`ticketOut` after that edge. A release at an edge moves `grant` to the next holder after that same edge, and a bad release shows `relError` one cycle after the edge that sampled it. The bench drives inputs on the falling edge and updates a behavioural model on each rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Directed phases cover single, simultaneous, repeated and illegal requests. A long pseudo-random phase then wraps the counters many times.

// File: rtl/tkl_pkg.sv
package tkl_pkg;

  // Strobes raised by control for the counter datapath
  typedef struct packed {
    logic serveAdvance;  // owner released: bump serving counter
    logic relFault;      // some non-owner released
  } tklStrobe_t;

endpackage

// File: rtl/tkl_ctrl.sv
module tkl_ctrl
  import tkl_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_AGENTS-1:0] acqReq,
  input  logic [NUM_AGENTS-1:0] relReq,
  input  logic [NUM_AGENTS-1:0] grant,
  output logic [NUM_AGENTS-1:0] takeMask,
  output logic [NUM_AGENTS-1:0] holdMask,
  output tklStrobe_t            strobe,
  output logic                  relError
);

  logic [NUM_AGENTS-1:0] hasTicket;
  logic [NUM_AGENTS-1:0] ownerRelease;
  logic [NUM_AGENTS-1:0] badRelease;

  // Agents already holding a ticket may not draw a second one
  assign takeMask     = acqReq & ~hasTicket;
  assign ownerRelease = relReq & grant;
  assign badRelease   = relReq & ~grant;
  assign holdMask     = hasTicket;

  always_comb begin
    strobe              = '0;
    strobe.serveAdvance = |ownerRelease;
    strobe.relFault     = |badRelease;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hasTicket <= '0;
      relError  <= 1'b0;
    end else begin
      hasTicket <= (hasTicket & ~ownerRelease) | takeMask;
      relError  <= strobe.relFault;
    end
  end

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  bad_release_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(relReq & ~grant)) |=> relError);

  // R4
  grant_needs_ticket_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~hasTicket) == '0);

  // R5
  owner_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(relReq & grant)) |=> ((hasTicket & $past(relReq & grant)) == '0));

endmodule

// File: rtl/tkl_datapath.sv
module tkl_datapath
  import tkl_pkg::*;
#(
  parameter int NUM_AGENTS = 4,
  parameter int CNT_W      = $clog2(NUM_AGENTS) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_AGENTS-1:0]       takeMask,
  input  logic [NUM_AGENTS-1:0]       holdMask,
  input  tklStrobe_t                  strobe,
  output logic [NUM_AGENTS*CNT_W-1:0] ticketOut,
  output logic [NUM_AGENTS-1:0]       grant
);

  logic [CNT_W-1:0] nextTicket;
  logic [CNT_W-1:0] nowServing;
  logic [CNT_W-1:0] ticketReg [NUM_AGENTS];
  logic [CNT_W-1:0] prefixOff [NUM_AGENTS];
  logic [CNT_W-1:0] issueCount;

  // Offset of each taker = number of lower-index takers this cycle
  always_comb begin
    issueCount = '0;
    for (int j = 0; j < NUM_AGENTS; j++) begin
      prefixOff[j] = issueCount;
      issueCount   = issueCount + CNT_W'(takeMask[j]);
    end
  end

  generate
    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
      always_ff @(posedge clk) begin
        if (!rst_n) ticketReg[i] <= '0;
        else if (takeMask[i]) ticketReg[i] <= nextTicket + prefixOff[i];
      end
      assign ticketOut[i*CNT_W +: CNT_W] = ticketReg[i];
      assign grant[i] = holdMask[i] && (ticketReg[i] == nowServing);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nextTicket <= '0;
      nowServing <= '0;
    end else begin
      nextTicket <= nextTicket + issueCount;
      if (strobe.serveAdvance) nowServing <= nowServing + CNT_W'(1);
    end
  end

  // R5
  serve_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.serveAdvance |=> $stable(nowServing));

  // R5
  serve_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.serveAdvance |=> (nowServing == $past(nowServing) + CNT_W'(1)));

  // R7
  issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (takeMask == '0) |=> $stable(nextTicket));

  // R9
  outstanding_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(nextTicket - nowServing) <= CNT_W'(NUM_AGENTS)));

endmodule

// File: rtl/ticket_lock_arbiter.sv
module ticket_lock_arbiter
  import tkl_pkg::*;
#(
  parameter int NUM_AGENTS = 4,
  parameter int CNT_W      = $clog2(NUM_AGENTS) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_AGENTS-1:0]       acqReq,
  input  logic [NUM_AGENTS-1:0]       relReq,
  output logic [NUM_AGENTS-1:0]       ticketValid,
  output logic [NUM_AGENTS*CNT_W-1:0] ticketOut,
  output logic [NUM_AGENTS-1:0]       grant,
  output logic                        relError
);

  logic [NUM_AGENTS-1:0] takeMask;
  logic [NUM_AGENTS-1:0] holdMask;
  tklStrobe_t            strobe;

  tkl_ctrl #(.NUM_AGENTS(NUM_AGENTS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .acqReq   (acqReq),
    .relReq   (relReq),
    .grant    (grant),
    .takeMask (takeMask),
    .holdMask (holdMask),
    .strobe   (strobe),
    .relError (relError)
  );

  tkl_datapath #(.NUM_AGENTS(NUM_AGENTS), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .takeMask  (takeMask),
    .holdMask  (holdMask),
    .strobe    (strobe),
    .ticketOut (ticketOut),
    .grant     (grant)
  );

  assign ticketValid = holdMask;

endmodule

// File: tb/ticket_lock_arbiter_tb.sv
module ticket_lock_arbiter_tb;

  localparam int N  = 4;
  localparam int W  = $clog2(N) + 1;
  localparam int MOD = 1 << W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   acqReq = '0;
  logic [N-1:0]   relReq = '0;
  logic [N-1:0]   ticketValid;
  logic [N*W-1:0] ticketOut;
  logic [N-1:0]   grant;
  logic           relError;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  int mTicket [N];
  bit mValid  [N];
  int mNext = 0;
  int mServe = 0;
  bit mErr = 0;
  int grantOrder [$];   // agents in expected grant order

  always #10 clk = ~clk;  // 50 MHz

  ticket_lock_arbiter #(.NUM_AGENTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .acqReq(acqReq), .relReq(relReq),
    .ticketValid(ticketValid), .ticketOut(ticketOut),
    .grant(grant), .relError(relError)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int modelHolder();
    for (int i = 0; i < N; i++)
      if (mValid[i] && mTicket[i] == mServe) return i;
    return -1;
  endfunction

  // model update for inputs sampled at a rising edge
  task automatic modelStep(input logic [N-1:0] a, input logic [N-1:0] r);
    int h;
    bit oldValid [N];
    h = modelHolder();
    for (int i = 0; i < N; i++) oldValid[i] = mValid[i];
    mErr = 0;
    for (int i = 0; i < N; i++) if (r[i] && i != h) mErr = 1;
    if (h >= 0 && r[h]) begin
      mValid[h] = 0;
      mServe = (mServe + 1) % MOD;
      void'(grantOrder.pop_front());
    end
    for (int i = 0; i < N; i++)
      if (a[i] && !oldValid[i]) begin
        mTicket[i] = mNext;
        mValid[i] = 1;
        mNext = (mNext + 1) % MOD;
        grantOrder.push_back(i);
      end
  endtask

  task automatic compareAll(input string tag);
    int h;
    h = modelHolder();
    for (int i = 0; i < N; i++) begin
      chk(ticketValid[i] == mValid[i], {tag, " R2 ticketValid"}, ticketValid[i], mValid[i]);
      if (mValid[i])
        chk(int'(ticketOut[i*W +: W]) == mTicket[i], {tag, " R3 ticket"},
            ticketOut[i*W +: W], mTicket[i]);
      chk(grant[i] == (i == h), {tag, " R4 grant"}, grant[i], (i == h));
    end
    chk($countones(grant) <= 1, {tag, " R8 single grant"}, $countones(grant), 1);
    if (grantOrder.size() > 0)
      chk(h == grantOrder[0], {tag, " R8 fifo order"}, h, grantOrder[0]);
    chk(relError == mErr, {tag, " R6 relError"}, relError, mErr);
  endtask

  task automatic step(input logic [N-1:0] a, input logic [N-1:0] r, input string tag);
    acqReq = a;
    relReq = r;
    @(posedge clk);
    modelStep(a, r);
    @(negedge clk);
    acqReq = '0;
    relReq = '0;
    compareAll(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] a;
    logic [N-1:0] r;
    int h;
    for (int i = 0; i < N; i++) begin mTicket[i] = 0; mValid[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(ticketValid == '0, "R1 no tickets", ticketValid, 0);
    chk(grant == '0, "R1 no grant", grant, 0);
    chk(relError == 1'b0, "R1 relError low", relError, 0);

    // R2 single acquire on a free lock
    step(4'b0100, '0, "R2");
    chk(int'(ticketOut[2*W +: W]) == 0, "R2 first ticket zero", ticketOut[2*W +: W], 0);
    chk(grant == 4'b0100, "R2 immediate grant", grant, 4'b0100);

    // R3 simultaneous acquires: 0,1,3 get 1,2,3
    step(4'b1011, '0, "R3");
    chk(int'(ticketOut[0 +: W]) == 1, "R3 agent0 ticket", ticketOut[0 +: W], 1);
    chk(int'(ticketOut[W +: W]) == 2, "R3 agent1 ticket", ticketOut[W +: W], 2);
    chk(int'(ticketOut[3*W +: W]) == 3, "R3 agent3 ticket", ticketOut[3*W +: W], 3);

    // R7 repeat acquire by holders ignored
    step(4'b1111, '0, "R7");
    chk(int'(ticketOut[2*W +: W]) == 0, "R7 ticket kept", ticketOut[2*W +: W], 0);

    // R6 release from non-owner
    step(4'b0000, 4'b0010, "R6");
    chk(relError == 1'b1, "R6 flag raised", relError, 1);
    chk(grant == 4'b0100, "R6 owner unchanged", grant, 4'b0100);
    step('0, '0, "R6");
    chk(relError == 1'b0, "R6 flag one cycle", relError, 0);

    // R5 owner release hands over in FIFO order
    step('0, 4'b0100, "R5");
    chk(grant == 4'b0001, "R5 next owner agent0", grant, 4'b0001);
    chk(ticketValid[2] == 1'b0, "R5 old owner dropped", ticketValid[2], 0);
    // owner releases while a non-owner also releases and agent2 re-acquires
    step(4'b0100, 4'b1001, "R5");
    chk(grant == 4'b0010, "R5 next owner agent1", grant, 4'b0010);
    chk(relError == 1'b1, "R6 mixed release flagged", relError, 1);
    chk(int'(ticketOut[2*W +: W]) == 4, "R7 new ticket after release", ticketOut[2*W +: W], 4);

    // R9 long run with wrap-around
    for (int c = 0; c < 6000; c++) begin
      a = N'($urandom);
      for (int i = 0; i < N; i++) if (($urandom % 10) < 6) a[i] = 1'b0;
      r = '0;
      h = modelHolder();
      if (h >= 0 && ($urandom % 10) < 5) r[h] = 1'b1;
      if (($urandom % 20) == 0) r[$urandom % N] = 1'b1;
      step(a, r, "R9");
    end
    chk(mNext >= 0 && mNext < MOD, "R9 model counter range", mNext, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule